// File: doc/BRIEF.md
# I/O Permission Bitmap Checker

This block decides whether a guest port I/O access must leave the guest. A check request carries the 16-bit port number, an access-info parameter word, the current instruction pointer, the instruction length, and the I/O intercept enable bit. When interception is off, the access is allowed without any memory traffic. When it is on, the block reads one 16-bit little-endian window of the permission bitmap and tests every byte of the accessed port range against it. A single access can therefore span two bitmap bytes.

The bitmap sits in external memory at a base address given on a plain control input. The block makes one read through a request/grant handshake, followed by a read-data return. It then produces a result carrying:
- the exit decision,
- a size-error flag,
- the two exit information words: the parameter word merged with the port number, and the address of the next instruction.

Both the check input and the result output are valid/ready streams. A check is accepted only when the block is idle. A result stays on the output, unchanged, until the consumer takes it. Performing the I/O and switching state are left to the surrounding logic.

Top module: `iopm_checker`

## Requirements
- R1: After reset, `chk_ready` is 1, `res_valid` is 0 and `mem_req` is 0.
- R2: With `io_intercept_en` low, an accepted check produces `res_exit`=0 and `res_size_err`=0 with `res_valid` high one cycle after acceptance, and no memory read is made.
- R3: The access width is taken from `chk_param[6:4]`. The legal values are 1, 2 and 4. The access mask is (1 << width) − 1, so a 1-byte access tests one bitmap bit and a 4-byte access tests four consecutive bits.
- R4: For an intercepted access, `mem_addr` equals `bitmap_base + (chk_port >> 3)`. `mem_req` stays high with a stable address until `mem_gnt` is seen, and each intercepted check performs exactly one read.
- R5: The returned word is little-endian: `mem_rdata[7:0]` is the byte at the request address and `mem_rdata[15:8]` the next byte. The mask is shifted left by `chk_port[2:0]`. The access exits if any shifted mask bit meets a set bitmap bit, including bits of the upper byte.
- R6: On an exit, `res_info1` equals `chk_param | (chk_port << 16)`.
- R7: On an exit, `res_info2` equals `chk_ip + chk_ilen`.
- R8: With interception enabled and an illegal width field (0, 3, 5, 6 or 7), the result has `res_exit`=1 and `res_size_err`=1, valid one cycle after acceptance, with no memory read.
- R9: For a fetched check, `res_valid` rises one cycle after the cycle in which `mem_rvalid` is high. While `res_valid` is high and `res_ready` is low, all result fields are held.
- R10: `chk_ready` is high only when the block is idle. A new check is not accepted while a read or a result is pending.
- R11: When `res_exit` is 0, `res_info1` and `res_info2` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chk_valid | input | 1 | Check request valid |
| chk_ready | output | 1 | Block idle and able to take a check |
| chk_port | input | PORT_W | Port number of the access |
| chk_param | input | PARAM_W | Access-info word; bits 6:4 give the width in bytes |
| chk_ip | input | IP_W | Current instruction pointer |
| chk_ilen | input | ILEN_W | Instruction length in bytes |
| io_intercept_en | input | 1 | I/O intercept enable, sampled with the check |
| bitmap_base | input | ADDR_W | Byte address of the permission bitmap, sampled with the check |
| mem_req | output | 1 | Bitmap read request |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_gnt | input | 1 | Read request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 8*WIN_BYTES | Read window, little-endian |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumer ready |
| res_exit | output | 1 | Access must exit |
| res_size_err | output | 1 | Width field was illegal |
| res_info1 | output | PARAM_W | Parameter word merged with the port number |
| res_info2 | output | IP_W | Next instruction address |

## Verification
The bench builds the block with its default parameters: a 16-bit port, a 32-bit parameter word, a 64-bit instruction pointer and a two-byte read window. These values put the top port 0xFFFF within reach, together with the last bitmap byte at offset 0x1FFF from a nonzero base. They also cover a 4-byte access at bit offset 7, which reaches three bits into the upper window byte. The grant delay and read latency in the bench vary from check to check, and the consumer stalls on a fixed pattern. This lets the bench check hold-until-grant, the one-cycle result latency, and the result hold under back-pressure across many timing combinations.

// File: rtl/iopm_pkg.sv
package iopm_pkg;

  // Position and width of the access width field in the parameter word.
  localparam int SIZE_LSB = 4;
  localparam int SIZE_W   = 3;

  // Bit position of the port number inside exit information word 1.
  localparam int EXIT_PORT_LSB = 16;

  // Sequencer states.
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_DONE = 2'd3
  } iopm_state_e;

endpackage

// File: rtl/iopm_size_decode.sv
// Turns the encoded access width into a byte mask and flags illegal codes.
module iopm_size_decode #(
  parameter int SIZE_W    = 3,
  parameter int MASK_W    = 8,
  parameter int MAX_BYTES = 4
) (
  input  logic [SIZE_W-1:0] size,
  output logic [MASK_W-1:0] mask,
  output logic              size_err
);

  // Bit b of the mask is set when b is below the width: (1 << size) - 1.
  for (genvar gb = 0; gb < MASK_W; gb++) begin : g_mask_bit
    assign mask[gb] = (32'(size) > gb);
  end

  // Legal widths are single powers of two up to the widest access.
  assign size_err = !($onehot(size) && (32'(size) <= MAX_BYTES));

endmodule

// File: rtl/iopm_window_test.sv
// Places the byte mask at the bit offset of the port and tests the window.
module iopm_window_test #(
  parameter int WIN_W     = 16,
  parameter int MASK_W    = 8,
  parameter int BIT_SEL_W = 3
) (
  input  logic [WIN_W-1:0]     window,
  input  logic [MASK_W-1:0]    mask,
  input  logic [BIT_SEL_W-1:0] bit_sel,
  output logic                 hit
);

  logic [WIN_W-1:0] placed;

  assign placed = WIN_W'(mask) << bit_sel;
  assign hit    = |(window & placed);

endmodule

// File: rtl/iopm_seq.sv
// Control sequencer: accept, read request, read wait, result hold.
module iopm_seq
  import iopm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic chk_valid,
  output logic chk_ready,
  input  logic need_fetch,
  output logic mem_req,
  input  logic mem_gnt,
  input  logic mem_rvalid,
  output logic res_valid,
  input  logic res_ready,
  output logic take_chk,
  output logic take_word
);

  iopm_state_e state_q, state_d;

  assign chk_ready = (state_q == ST_IDLE);
  assign mem_req   = (state_q == ST_REQ);
  assign res_valid = (state_q == ST_DONE);
  assign take_chk  = chk_ready && chk_valid;
  assign take_word = (state_q == ST_WAIT) && mem_rvalid;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (chk_valid)  state_d = need_fetch ? ST_REQ : ST_DONE;
      ST_REQ:  if (mem_gnt)    state_d = ST_WAIT;
      ST_WAIT: if (mem_rvalid) state_d = ST_DONE;
      ST_DONE: if (res_ready)  state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // R9: read data return yields a valid result on the next cycle.
  p_rvalid_result_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && mem_rvalid) |=> res_valid);

  // R10: nothing is accepted while a read or a result is outstanding.
  p_idle_only_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    chk_ready |-> (!res_valid && !mem_req));

endmodule

// File: rtl/iopm_checker.sv
module iopm_checker #(
  parameter int PORT_W    = 16,
  parameter int PARAM_W   = 32,
  parameter int IP_W      = 64,
  parameter int ILEN_W    = 4,
  parameter int ADDR_W    = 32,
  parameter int WIN_BYTES = 2,
  parameter int MAX_BYTES = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   chk_valid,
  output logic                   chk_ready,
  input  logic [PORT_W-1:0]      chk_port,
  input  logic [PARAM_W-1:0]     chk_param,
  input  logic [IP_W-1:0]        chk_ip,
  input  logic [ILEN_W-1:0]      chk_ilen,
  input  logic                   io_intercept_en,
  input  logic [ADDR_W-1:0]      bitmap_base,
  output logic                   mem_req,
  output logic [ADDR_W-1:0]      mem_addr,
  input  logic                   mem_gnt,
  input  logic                   mem_rvalid,
  input  logic [8*WIN_BYTES-1:0] mem_rdata,
  output logic                   res_valid,
  input  logic                   res_ready,
  output logic                   res_exit,
  output logic                   res_size_err,
  output logic [PARAM_W-1:0]     res_info1,
  output logic [IP_W-1:0]        res_info2
);

  import iopm_pkg::*;

  localparam int WIN_W     = 8 * WIN_BYTES;
  localparam int BIT_SEL_W = 3;
  localparam int MASK_W    = 8;

  // Live decode of the incoming check.
  logic [MASK_W-1:0]  mask_live;
  logic               err_live;
  logic               need_fetch;
  logic               reject_live;
  logic [PARAM_W-1:0] info1_live;
  logic [IP_W-1:0]    info2_live;

  // Held copy of the accepted check.
  logic [PORT_W-1:0]  port_q;
  logic [PARAM_W-1:0] param_q;
  logic [IP_W-1:0]    nip_q;
  logic [ADDR_W-1:0]  base_q;
  logic [MASK_W-1:0]  mask_q;
  logic [PARAM_W-1:0] info1_held;

  logic take_chk;
  logic take_word;
  logic win_hit;

  iopm_size_decode #(
    .SIZE_W   (SIZE_W),
    .MASK_W   (MASK_W),
    .MAX_BYTES(MAX_BYTES)
  ) u_size (
    .size    (chk_param[SIZE_LSB +: SIZE_W]),
    .mask    (mask_live),
    .size_err(err_live)
  );

  assign need_fetch  = io_intercept_en && !err_live;
  assign reject_live = io_intercept_en && err_live;
  assign info1_live  = chk_param | (PARAM_W'(chk_port) << EXIT_PORT_LSB);
  assign info2_live  = chk_ip + IP_W'(chk_ilen);
  assign info1_held  = param_q | (PARAM_W'(port_q) << EXIT_PORT_LSB);

  iopm_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .chk_valid (chk_valid),
    .chk_ready (chk_ready),
    .need_fetch(need_fetch),
    .mem_req   (mem_req),
    .mem_gnt   (mem_gnt),
    .mem_rvalid(mem_rvalid),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .take_chk  (take_chk),
    .take_word (take_word)
  );

  iopm_window_test #(
    .WIN_W    (WIN_W),
    .MASK_W   (MASK_W),
    .BIT_SEL_W(BIT_SEL_W)
  ) u_win (
    .window (mem_rdata),
    .mask   (mask_q),
    .bit_sel(port_q[BIT_SEL_W-1:0]),
    .hit    (win_hit)
  );

  // Byte address of the bitmap window holding the first port of the access.
  assign mem_addr = base_q + ADDR_W'(port_q >> BIT_SEL_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q  <= '0;
      param_q <= '0;
      nip_q   <= '0;
      base_q  <= '0;
      mask_q  <= '0;
    end else if (take_chk) begin
      port_q  <= chk_port;
      param_q <= chk_param;
      nip_q   <= info2_live;
      base_q  <= bitmap_base;
      mask_q  <= mask_live;
    end
  end

  // Result registers: loaded at acceptance for bypass/reject, at data return otherwise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_exit     <= 1'b0;
      res_size_err <= 1'b0;
      res_info1    <= '0;
      res_info2    <= '0;
    end else if (take_chk) begin
      res_exit     <= reject_live;
      res_size_err <= reject_live;
      res_info1    <= reject_live ? info1_live : '0;
      res_info2    <= reject_live ? info2_live : '0;
    end else if (take_word) begin
      res_exit     <= win_hit;
      res_size_err <= 1'b0;
      res_info1    <= win_hit ? info1_held : '0;
      res_info2    <= win_hit ? nip_q : '0;
    end
  end

  // R3: a read is only issued for a legal 1, 2 or 4 byte mask.
  p_mask_legal_r3 : assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mask_q) == 1 || $countones(mask_q) == 2 ||
                 $countones(mask_q) == 4));

  // R4: request and address hold until granted.
  p_req_hold_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

  // R8: an illegal width always exits.
  p_err_exit_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_size_err) |-> res_exit);

  // R9: result fields hold under back-pressure.
  p_res_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_exit) && $stable(res_size_err) &&
       $stable(res_info1) && $stable(res_info2)));

  // R11: no exit carries zeroed information words.
  p_noexit_zero_r11 : assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_exit) |-> (res_info1 == '0 && res_info2 == '0));

endmodule

// File: tb/iopm_checker_tb.sv
module iopm_checker_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        chk_valid;
  logic        chk_ready;
  logic [15:0] chk_port;
  logic [31:0] chk_param;
  logic [63:0] chk_ip;
  logic [3:0]  chk_ilen;
  logic        io_intercept_en;
  logic [31:0] bitmap_base;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_gnt;
  logic        mem_rvalid;
  logic [15:0] mem_rdata;
  logic        res_valid;
  logic        res_ready;
  logic        res_exit;
  logic        res_size_err;
  logic [31:0] res_info1;
  logic [63:0] res_info2;

  always #(CLK_PERIOD / 2) clk = ~clk;

  iopm_checker u_dut (
    .clk(clk), .rst_n(rst_n),
    .chk_valid(chk_valid), .chk_ready(chk_ready),
    .chk_port(chk_port), .chk_param(chk_param), .chk_ip(chk_ip), .chk_ilen(chk_ilen),
    .io_intercept_en(io_intercept_en), .bitmap_base(bitmap_base),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .res_valid(res_valid), .res_ready(res_ready), .res_exit(res_exit),
    .res_size_err(res_size_err), .res_info1(res_info1), .res_info2(res_info2)
  );

  typedef struct {
    logic        ex;
    logic        er;
    logic [31:0] i1;
    logic [63:0] i2;
    string       req;
  } exp_t;

  exp_t        sbq[$];
  int          checks = 0;
  int          errors = 0;
  int          nreads = 0;
  int          cyc = 0;
  logic [31:0] exp_addr;
  bit          force_en = 1'b0;
  logic [15:0] force_word = '0;
  bit          done = 1'b0;

  function automatic logic [7:0] byte_at(logic [31:0] a);
    return 8'(a * 29) ^ 8'(a >> 5) ^ 8'h5A;
  endfunction

  function automatic logic [15:0] word_at(logic [31:0] a);
    if (force_en) return force_word;
    return {byte_at(a + 1), byte_at(a)};
  endfunction

  task automatic check_eq(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Driver: computes the expected result, pushes it, and offers the check.
  task automatic run_check(input logic [15:0] port, input logic [31:0] param,
                           input logic [63:0] ip, input logic [3:0] ilen,
                           input bit en, input logic [31:0] base, input string req);
    exp_t        e;
    int          sz = int'(param[6:4]);
    bit          legal = (sz == 1 || sz == 2 || sz == 4);
    bit          fetch = en && legal;
    int          r0 = nreads;
    logic [15:0] m16;
    logic        hit;
    e.req = req;
    exp_addr = base + 32'(port >> 3);
    if (!en) begin
      hit = 1'b0; e.er = 1'b0;
    end else if (!legal) begin
      hit = 1'b1; e.er = 1'b1;
    end else begin
      m16 = 16'(((16'd1 << sz) - 16'd1) << port[2:0]);
      hit = |(word_at(exp_addr) & m16);
      e.er = 1'b0;
    end
    e.ex = hit;
    e.i1 = hit ? (param | (32'(port) << 16)) : 32'h0;
    e.i2 = hit ? (ip + 64'(ilen)) : 64'h0;
    sbq.push_back(e);
    @(negedge clk);
    while (!chk_ready) @(negedge clk);
    chk_port = port; chk_param = param; chk_ip = ip; chk_ilen = ilen;
    io_intercept_en = en; bitmap_base = base; chk_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk_valid = 1'b0;
    if (!fetch) check_eq(en ? "R8" : "R2", "res_valid one cycle after accept", 64'(res_valid), 64'd1);
    wait (sbq.size() == 0);
    @(negedge clk);
    check_eq(fetch ? "R4" : (en ? "R8" : "R2"), "read count", 64'(nreads - r0), fetch ? 64'd1 : 64'd0);
  endtask

  // Memory responder with varying grant delay and read latency.
  initial begin
    mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) begin
        repeat (nreads % 3) begin
          @(negedge clk);
          check_eq("R4", "request held until grant", 64'(mem_req), 64'd1);
        end
        check_eq("R4", "bitmap address", 64'(mem_addr), 64'(exp_addr));
        check_eq("R10", "ready low while busy", 64'(chk_ready), 64'd0);
        mem_gnt = 1'b1;
        @(negedge clk);
        mem_gnt = 1'b0;
        nreads++;
        repeat (nreads % 2) @(negedge clk);
        check_eq("R9", "no result before data", 64'(res_valid), 64'd0);
        mem_rvalid = 1'b1;
        mem_rdata  = word_at(exp_addr);
        @(negedge clk);
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
        check_eq("R9", "result one cycle after data", 64'(res_valid), 64'd1);
      end
    end
  end

  // Monitor: drives back-pressure and compares results against the scoreboard.
  initial begin
    bit   stalled = 1'b0;
    exp_t e;
    res_ready = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      res_ready = rst_n && (cyc % 3 != 0);
      if (res_valid && !res_ready) stalled = 1'b1;
      if (res_valid && res_ready) begin
        if (sbq.size() == 0) begin
          check_eq("R10", "unexpected result", 64'd1, 64'd0);
        end else begin
          e = sbq.pop_front();
          check_eq(e.req, stalled ? "exit (R9 after stall)" : "exit", 64'(res_exit), 64'(e.ex));
          check_eq(e.req, "size error", 64'(res_size_err), 64'(e.er));
          check_eq(e.ex ? "R6" : "R11", "info1", 64'(res_info1), 64'(e.i1));
          check_eq(e.ex ? "R7" : "R11", "info2", res_info2, e.i2);
        end
        stalled = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; chk_valid = 1'b0; chk_port = '0; chk_param = '0; chk_ip = '0;
    chk_ilen = '0; io_intercept_en = 1'b0; bitmap_base = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1", "chk_ready after reset", 64'(chk_ready), 64'd1);
    check_eq("R1", "res_valid after reset", 64'(res_valid), 64'd0);
    check_eq("R1", "mem_req after reset", 64'(mem_req), 64'd0);

    // R2: interception off, no read, no exit; also with an illegal width.
    run_check(16'h0060, 32'h0000_0011, 64'h1000, 4'd2, 1'b0, 32'h0, "R2");
    run_check(16'h0061, 32'h0000_0071, 64'h1000, 4'd2, 1'b0, 32'h0, "R2");

    force_en = 1'b1;
    // R3/R5: 1-byte access at bit 0 of the low byte, set and clear.
    force_word = 16'h0001;
    run_check(16'h0010, 32'h0000_0010, 64'h2000, 4'd1, 1'b1, 32'h0, "R3");
    run_check(16'h0011, 32'h0000_0010, 64'h2000, 4'd1, 1'b1, 32'h0, "R11");
    // R5: 2-byte access at bit 7 straddles into the upper byte.
    force_word = 16'h0100;
    run_check(16'h0017, 32'h0000_0021, 64'h3000, 4'd3, 1'b1, 32'h0, "R5");
    run_check(16'h0016, 32'h0000_0021, 64'h3000, 4'd3, 1'b1, 32'h0, "R5");
    // R3: 4-byte access covers bits 5..8.
    run_check(16'h001D, 32'h0000_0049, 64'h4000, 4'd2, 1'b1, 32'h0, "R3");
    force_word = 16'h0010;
    run_check(16'h001D, 32'h0000_0049, 64'h4000, 4'd2, 1'b1, 32'h0, "R3");
    force_word = 16'h0080;
    run_check(16'h000C, 32'h0000_0040, 64'h4000, 4'd2, 1'b1, 32'h0, "R3");
    // R4/R6/R7: top port with nonzero base, bits 7..10.
    force_word = 16'h0400;
    run_check(16'hFFFF, 32'h0000_0041, 64'hFFFF_FFFF_FFFF_FFFE, 4'd5, 1'b1, 32'h0001_0000, "R6");
    force_word = 16'h0800;
    run_check(16'hFFFF, 32'h0000_0041, 64'h5000, 4'd1, 1'b1, 32'h0001_0000, "R7");
    // R8: illegal width codes.
    run_check(16'h0020, 32'h0000_0001, 64'h6000, 4'd1, 1'b1, 32'h0, "R8");
    run_check(16'h0021, 32'h0000_0030, 64'h6000, 4'd1, 1'b1, 32'h0, "R8");
    run_check(16'h0022, 32'h0000_0070, 64'h6000, 4'd1, 1'b1, 32'h0, "R8");

    // Pseudo-random bitmap and accesses.
    force_en = 1'b0;
    for (int i = 0; i < 60; i++) begin
      logic [2:0]  code = (i % 4 == 0) ? 3'd1 : (i % 4 == 1) ? 3'd2 : (i % 4 == 2) ? 3'd4 : 3'(i % 8);
      logic [31:0] p = {$urandom} & 32'h0000_FF8F;
      p[6:4] = code;
      run_check(16'($urandom), p, {$urandom, $urandom}, 4'($urandom), (i % 7 != 0),
                32'($urandom) & 32'hFFFF_0000, "R5");
    end

    repeat (4) @(negedge clk);
    finish_up();
  end

endmodule